// File: doc/BRIEF.md
# Serial DAC Host Sequencer

This block sits on the host side of a 16-bit voltage-output DAC that is reached through four wires: an active-low select, a serial clock, a data line and an active-low load strobe. Software or a neighbouring state machine hands it one command at a time over a valid/ready pair. The block turns each command into the pin waveform the converter expects. It keeps every edge on the load strobe inside windows where select is high, so a strobe line shared with other converters never corrupts a transfer.

Five commands exist. There are two kinds of code write: one updates the output as select rises, the other leaves the update for a later strobe. There is also a bare load strobe. Finally there is a power-down and a wake-up. The converter has no power-down command word, so the block produces it from pin activity alone. It toggles the serial clock once, pulses select low twice, and then leaves the clock frozen. Wake-up moves the clock back, then holds the command port busy for a settling wait. A write issued while the converter sleeps runs the wake-up first on its own. The clock half-period, the select setup and hold margin, the minimum select-high and strobe width, and the wake wait are all parameters counted in clock cycles.

Top module: `sdac_host`

## Requirements
- R1: After reset, and whenever the block is idle and the converter is awake, dac_cs_n=1, dac_sclk=0, dac_ldac_n=1 and cmd_ready=1.
- R2: A write (cmd_op 0 or 1) produces exactly one dac_cs_n low window holding exactly 16 rising dac_sclk edges. The bits of cmd_code are presented most significant first, so bit 15 is sampled at the first rise.
- R3: For cmd_op 0 (write, update at once), dac_ldac_n falls before dac_cs_n falls and stays low for the whole select window. It returns high only after dac_cs_n is high again.
- R4: For cmd_op 1 (write, update later), dac_ldac_n stays high for the whole select window and no strobe is emitted. In every select window, dac_ldac_n never changes while dac_cs_n is low.
- R5: cmd_op 2 emits one dac_ldac_n low pulse of exactly GAP_CYC cycles with dac_cs_n high. dac_ldac_n changes level only when dac_cs_n is high in both the cycle before and the cycle after the change.
- R6: dac_din changes only while dac_sclk is low, so it is stable across every rising dac_sclk edge.
- R7: cmd_op 3 on an awake converter gives one dac_sclk transition while dac_cs_n is high. Two dac_cs_n low pulses follow with no rising dac_sclk inside them. dac_sclk then stays at its toggled level until a wake.
- R8: cmd_op 3 while already powered down produces no pin activity.
- R9: cmd_op 4 while powered down makes exactly one dac_sclk transition and no select edge. It holds cmd_ready low for at least WAKE_CYC cycles. cmd_op 4 while awake produces no pin activity.
- R10: A write accepted while powered down first performs the wake sequence, including the full WAKE_CYC wait, and then performs the write unchanged.
- R11: cmd_ready drops in the cycle after a command is accepted and stays low until its sequence ends. cmd_op values 5 to 7 are accepted with no pin activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | 0 write-now, 1 write-later, 2 strobe, 3 power-down, 4 wake |
| cmd_code | input | 16 | Code for write commands |
| dac_cs_n | output | 1 | Active-low converter select |
| dac_sclk | output | 1 | Serial clock to converter |
| dac_din | output | 1 | Serial data to converter |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
The embedded properties take for granted that rst is synchronous and that cmd_valid, cmd_op and cmd_code are driven synchronously to clk. They also assume no other agent moves the converter pins. The properties therefore judge the block's own pins alone and say nothing about a shared strobe driven from elsewhere. The stimulus drives all command inputs half a cycle away from the sampling edge. It offers a command only after it has seen cmd_ready high, and it drops cmd_valid after one cycle, so every handshake is a clean single-cycle accept.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_WR_NOW   = 3'd0,
        OP_WR_LATER = 3'd1,
        OP_STROBE   = 3'd2,
        OP_SLEEP    = 3'd3,
        OP_WAKE     = 3'd4
    } sdac_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DONE,
        ST_WAKE,
        ST_LD_PRE,
        ST_CS_LEAD,
        ST_SHIFT,
        ST_CS_TRAIL,
        ST_GAP,
        ST_LD_PULSE,
        ST_SLP_TOG,
        ST_SLP_LO,
        ST_SLP_HI
    } sdac_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic ldac_n;
    } sdac_pins_t;

    typedef struct packed {
        sdac_op_e          op;
        logic [WORD_W-1:0] code;
    } sdac_cmd_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic is_write(input sdac_op_e op);
        return (op == OP_WR_NOW) || (op == OP_WR_LATER);
    endfunction

endpackage

// File: rtl/sdac_timer.sv
module sdac_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic         rise,
    input  logic         fall,
    output logic         bit_o,
    output logic         last
);
    logic [W-1:0]  sreg;
    logic [CW-1:0] edges;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            edges <= '0;
        end else if (load) begin
            sreg  <= data;
            edges <= '0;
        end else begin
            if (rise) edges <= edges + 1'b1;
            if (fall) sreg  <= {sreg[W-2:0], 1'b0};
        end
    end

    assign bit_o = sreg[W-1];
    assign last  = (edges == CW'(W));

    AST_NO_EXTRA_EDGE: assert property (@(posedge clk) disable iff (rst)
        rise |-> (edges < CW'(W))); // R2

    AST_SHIFT_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        fall |-> (edges != '0)); // R6

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq
    import sdac_pkg::*;
#(
    parameter int HALF_CYC  = 5,
    parameter int SETUP_CYC = 2,
    parameter int GAP_CYC   = 4,
    parameter int WAKE_CYC  = 10000,
    parameter int TW        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_code,
    output logic              cmd_ready,
    output sdac_pins_t        pins,
    output logic              sh_load,
    output logic [WORD_W-1:0] sh_data,
    output logic              sh_rise,
    output logic              sh_fall,
    input  logic              sh_last,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic              tmr_done
);
    localparam logic [TW-1:0] T_HALF  = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_GAP   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] T_WAKE  = TW'(WAKE_CYC - 1);

    sdac_state_e state, state_d;
    sdac_pins_t  pins_q, pins_d;
    sdac_cmd_t   cmd_q, cmd_d;
    logic        asleep, asleep_d;
    logic        pend_q, pend_d;
    logic        second_q, second_d;
    logic        begin_wr;
    sdac_op_e    in_op;
    sdac_op_e    wr_op;

    assign in_op     = sdac_op_e'(cmd_op);
    assign cmd_ready = (state == ST_IDLE);
    assign pins      = pins_q;

    always_comb begin
        state_d  = state;
        pins_d   = pins_q;
        cmd_d    = cmd_q;
        asleep_d = asleep;
        pend_d   = pend_q;
        second_d = second_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_data  = cmd_q.code;
        sh_rise  = 1'b0;
        sh_fall  = 1'b0;
        begin_wr = 1'b0;
        wr_op    = cmd_q.op;

        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    cmd_d.op   = in_op;
                    cmd_d.code = cmd_code;
                    wr_op      = in_op;
                    sh_data    = cmd_code;
                    if (is_write(in_op)) begin
                        if (asleep) begin
                            pins_d.sclk = ~pins_q.sclk;
                            asleep_d    = 1'b0;
                            pend_d      = 1'b1;
                            state_d     = ST_WAKE;
                            tmr_load    = 1'b1;
                            tmr_val     = T_WAKE;
                        end else begin
                            begin_wr = 1'b1;
                        end
                    end else if (in_op == OP_STROBE) begin
                        pins_d.ldac_n = 1'b0;
                        state_d       = ST_LD_PULSE;
                        tmr_load      = 1'b1;
                        tmr_val       = T_GAP;
                    end else if (in_op == OP_SLEEP && !asleep) begin
                        pins_d.sclk = ~pins_q.sclk;
                        second_d    = 1'b0;
                        state_d     = ST_SLP_TOG;
                        tmr_load    = 1'b1;
                        tmr_val     = T_SETUP;
                    end else if (in_op == OP_WAKE && asleep) begin
                        pins_d.sclk = ~pins_q.sclk;
                        asleep_d    = 1'b0;
                        pend_d      = 1'b0;
                        state_d     = ST_WAKE;
                        tmr_load    = 1'b1;
                        tmr_val     = T_WAKE;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            ST_WAKE: begin
                if (tmr_done) begin
                    if (pend_q) begin
                        pend_d   = 1'b0;
                        begin_wr = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LD_PRE: begin
                if (tmr_done) begin
                    pins_d.cs_n = 1'b0;
                    sh_load     = 1'b1;
                    state_d     = ST_CS_LEAD;
                    tmr_load    = 1'b1;
                    tmr_val     = T_SETUP;
                end
            end
            ST_CS_LEAD: begin
                if (tmr_done) begin
                    state_d  = ST_SHIFT;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_SHIFT: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                    if (!pins_q.sclk) begin
                        pins_d.sclk = 1'b1;
                        sh_rise     = 1'b1;
                    end else begin
                        pins_d.sclk = 1'b0;
                        if (sh_last) begin
                            state_d = ST_CS_TRAIL;
                            tmr_val = T_SETUP;
                        end else begin
                            sh_fall = 1'b1;
                        end
                    end
                end
            end
            ST_CS_TRAIL: begin
                if (tmr_done) begin
                    pins_d.cs_n = 1'b1;
                    state_d     = ST_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = T_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    pins_d.ldac_n = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            ST_LD_PULSE: begin
                if (tmr_done) begin
                    pins_d.ldac_n = 1'b1;
                    state_d       = ST_GAP;
                    tmr_load      = 1'b1;
                    tmr_val       = T_GAP;
                end
            end
            ST_SLP_TOG: begin
                if (tmr_done) begin
                    pins_d.cs_n = 1'b0;
                    state_d     = ST_SLP_LO;
                    tmr_load    = 1'b1;
                    tmr_val     = T_GAP;
                end
            end
            ST_SLP_LO: begin
                if (tmr_done) begin
                    pins_d.cs_n = 1'b1;
                    state_d     = ST_SLP_HI;
                    tmr_load    = 1'b1;
                    tmr_val     = T_GAP;
                end
            end
            ST_SLP_HI: begin
                if (tmr_done) begin
                    if (!second_q) begin
                        second_d    = 1'b1;
                        pins_d.cs_n = 1'b0;
                        state_d     = ST_SLP_LO;
                        tmr_load    = 1'b1;
                        tmr_val     = T_GAP;
                    end else begin
                        asleep_d = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (begin_wr) begin
            tmr_load = 1'b1;
            tmr_val  = T_SETUP;
            if (wr_op == OP_WR_NOW) begin
                pins_d.ldac_n = 1'b0;
                state_d       = ST_LD_PRE;
            end else begin
                pins_d.cs_n = 1'b0;
                sh_load     = 1'b1;
                state_d     = ST_CS_LEAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pins_q   <= '{cs_n: 1'b1, sclk: 1'b0, ldac_n: 1'b1};
            cmd_q    <= '{op: OP_WR_NOW, code: '0};
            asleep   <= 1'b0;
            pend_q   <= 1'b0;
            second_q <= 1'b0;
        end else begin
            state    <= state_d;
            pins_q   <= pins_d;
            cmd_q    <= cmd_d;
            asleep   <= asleep_d;
            pend_q   <= pend_d;
            second_q <= second_d;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !asleep) |-> (pins_q.cs_n && !pins_q.sclk && pins_q.ldac_n)); // R1

    AST_LDAC_EDGE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pins_q.ldac_n != $past(pins_q.ldac_n)) |-> (pins_q.cs_n && $past(pins_q.cs_n))); // R5

    AST_LDAC_STEADY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.cs_n && !$past(pins_q.cs_n)) |-> $stable(pins_q.ldac_n)); // R4

    AST_SCLK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (asleep && $past(asleep)) |-> $stable(pins_q.sclk)); // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R11

    AST_SLEEP_NO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLP_LO) |-> !pins_q.sclk || $stable(pins_q.sclk)); // R7

endmodule

// File: rtl/sdac_host.sv
module sdac_host
    import sdac_pkg::*;
#(
    parameter int HALF_CYC  = 5,
    parameter int SETUP_CYC = 2,
    parameter int GAP_CYC   = 4,
    parameter int WAKE_CYC  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_code,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_din,
    output logic              dac_ldac_n
);
    localparam int MAX_CYC = max4(HALF_CYC, SETUP_CYC, GAP_CYC, WAKE_CYC);
    localparam int TW      = $clog2(MAX_CYC + 1) + 1;

    sdac_pins_t        pins;
    logic              sh_load, sh_rise, sh_fall, sh_last, sh_bit;
    logic [WORD_W-1:0] sh_data;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;

    sdac_seq #(
        .HALF_CYC  (HALF_CYC),
        .SETUP_CYC (SETUP_CYC),
        .GAP_CYC   (GAP_CYC),
        .WAKE_CYC  (WAKE_CYC),
        .TW        (TW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_code  (cmd_code),
        .cmd_ready (cmd_ready),
        .pins      (pins),
        .sh_load   (sh_load),
        .sh_data   (sh_data),
        .sh_rise   (sh_rise),
        .sh_fall   (sh_fall),
        .sh_last   (sh_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_done  (tmr_done)
    );

    sdac_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .data  (sh_data),
        .rise  (sh_rise),
        .fall  (sh_fall),
        .bit_o (sh_bit),
        .last  (sh_last)
    );

    sdac_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign dac_cs_n   = pins.cs_n;
    assign dac_sclk   = pins.sclk;
    assign dac_ldac_n = pins.ldac_n;
    assign dac_din    = sh_bit;

    AST_DIN_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_sclk) |-> $stable(dac_din)); // R6

endmodule

// File: tb/test_sdac_host.sv
module test_sdac_host;
    localparam int HALF  = 5;
    localparam int SETUP = 2;
    localparam int GAP   = 4;
    localparam int WAKE  = 10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_code = '0;
    logic        dac_cs_n, dac_sclk, dac_din, dac_ldac_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdac_host #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP), .WAKE_CYC(WAKE)) i_sdac_host (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_code(cmd_code), .dac_cs_n(dac_cs_n),
        .dac_sclk(dac_sclk), .dac_din(dac_din), .dac_ldac_n(dac_ldac_n)
    );

    // pin monitor, sampled on the falling clock edge
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_ldac = 1'b1, p_din = 1'b0;
    logic [15:0] shreg = '0, last_word = '0;
    int rises = 0, last_rises = 0, total_rises = 0;
    logic fr_lo = 1'b0, fr_hi = 1'b0, last_lo = 1'b0, last_hi = 1'b0;
    int cs_falls = 0, ldac_falls = 0, ldac_bad = 0, din_bad = 0;
    int sclk_cs_hi = 0, pin_ev = 0, ldac_run = 0, last_ldac_w = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_cs_n != p_cs || dac_sclk != p_sclk || dac_ldac_n != p_ldac) pin_ev++;
            if (p_cs && !dac_cs_n) begin
                shreg = '0; rises = 0; fr_lo = 1'b1; fr_hi = 1'b1; cs_falls++;
            end
            if (!dac_cs_n) begin
                if (dac_ldac_n) fr_lo = 1'b0; else fr_hi = 1'b0;
            end
            if (!p_sclk && dac_sclk && !dac_cs_n) begin
                shreg = {shreg[14:0], dac_din}; rises++; total_rises++;
            end
            if (dac_sclk && dac_din != p_din) din_bad++;
            if (!p_cs && dac_cs_n) begin
                last_word = shreg; last_rises = rises; last_lo = fr_lo; last_hi = fr_hi;
            end
            if (p_ldac && !dac_ldac_n) ldac_falls++;
            if (dac_ldac_n != p_ldac && !(dac_cs_n && p_cs)) ldac_bad++;
            if (!dac_ldac_n) ldac_run++;
            if (!p_ldac && dac_ldac_n) begin last_ldac_w = ldac_run; ldac_run = 0; end
            if (dac_sclk != p_sclk && dac_cs_n) sclk_cs_hi++;
        end
        p_cs = dac_cs_n; p_sclk = dac_sclk; p_ldac = dac_ldac_n; p_din = dac_din;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [15:0] code,
                        output int busy, output bit dropped);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        dropped = !cmd_ready;
        busy = 0;
        while (!cmd_ready) begin busy++; @(negedge clk); end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(dac_cs_n && !dac_sclk && dac_ldac_n, "R1 reset pins", {dac_cs_n, dac_sclk, dac_ldac_n}, 3'b101);
        chk(cmd_ready, "R1 ready after reset", cmd_ready, 1);
    endtask

    task automatic t_write_now(input logic [15:0] code);
        int busy; bit dr; int f0;
        f0 = cs_falls;
        send(3'd0, code, busy, dr);
        chk(dr, "R11 ready drop", !dr, 0);
        chk(last_word == code, "R2 word now", last_word, code);
        chk(last_rises == 16 && cs_falls == f0 + 1, "R2 edge count", last_rises, 16);
        chk(last_lo, "R3 ldac low in frame", last_lo, 1);
        chk(dac_ldac_n && !dac_sclk, "R3 ldac released, R1 sclk idle", {dac_ldac_n, dac_sclk}, 2'b10);
    endtask

    task automatic t_write_later(input logic [15:0] code);
        int busy; bit dr; int l0;
        l0 = ldac_falls;
        send(3'd1, code, busy, dr);
        chk(last_word == code && last_rises == 16, "R2 word later", last_word, code);
        chk(last_hi && ldac_falls == l0, "R4 ldac high in frame", ldac_falls - l0, 0);
    endtask

    task automatic t_strobe();
        int busy; bit dr; int l0, f0;
        l0 = ldac_falls; f0 = cs_falls;
        send(3'd2, 16'h0, busy, dr);
        chk(ldac_falls == l0 + 1 && cs_falls == f0, "R5 one strobe", ldac_falls - l0, 1);
        chk(last_ldac_w == GAP, "R5 strobe width", last_ldac_w, GAP);
    endtask

    task automatic t_sleep();
        int busy; bit dr; int f0, s0, r0, e0;
        f0 = cs_falls; s0 = sclk_cs_hi; r0 = total_rises;
        send(3'd3, 16'h0, busy, dr);
        chk(cs_falls == f0 + 2, "R7 two select pulses", cs_falls - f0, 2);
        chk(sclk_cs_hi == s0 + 1 && total_rises == r0, "R7 one clock toggle", sclk_cs_hi - s0, 1);
        e0 = pin_ev;
        repeat (50) @(negedge clk);
        chk(dac_sclk && pin_ev == e0, "R7 clock frozen high", dac_sclk, 1);
    endtask

    task automatic t_sleep_again();
        int busy; bit dr; int e0;
        e0 = pin_ev;
        send(3'd3, 16'h0, busy, dr);
        chk(pin_ev == e0 && dac_sclk, "R8 repeat sleep silent", pin_ev - e0, 0);
    endtask

    task automatic t_wake();
        int busy; bit dr; int s0, f0;
        s0 = sclk_cs_hi; f0 = cs_falls;
        send(3'd4, 16'h0, busy, dr);
        chk(busy >= WAKE, "R9 wake wait", busy, WAKE);
        chk(sclk_cs_hi == s0 + 1 && cs_falls == f0 && !dac_sclk, "R9 one clock move", sclk_cs_hi - s0, 1);
    endtask

    task automatic t_wake_awake();
        int busy; bit dr; int e0;
        e0 = pin_ev;
        send(3'd4, 16'h0, busy, dr);
        chk(pin_ev == e0 && busy < WAKE, "R9 wake while awake silent", pin_ev - e0, 0);
    endtask

    task automatic t_write_asleep(input logic [15:0] code);
        int busy; bit dr;
        send(3'd1, code, busy, dr);
        chk(busy >= WAKE + 16 * 2 * HALF, "R10 auto wake wait", busy, WAKE + 16 * 2 * HALF);
        chk(last_word == code && last_rises == 16 && !dac_sclk, "R10 write after wake", last_word, code);
    endtask

    task automatic t_bad_op();
        int busy; bit dr; int e0;
        e0 = pin_ev;
        send(3'd6, 16'hFFFF, busy, dr);
        chk(dr && pin_ev == e0 && busy <= 2, "R11 unused op", pin_ev - e0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_now(16'hA5C3);
        t_write_now(16'h8000);
        t_write_later(16'h0001);
        t_strobe();
        t_write_later(16'hFFFF);
        t_wake_awake();
        t_bad_op();
        t_sleep();
        t_sleep_again();
        t_wake();
        t_write_now(16'h0000);
        t_sleep();
        t_write_asleep(16'h3C5A);
        t_write_now(16'h7FFE);
        chk(din_bad == 0, "R6 data steady while clock high", din_bad, 0);
        chk(ldac_bad == 0, "R5 strobe edges only with select high", ldac_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule